// File: doc/BRIEF.md
# Paired Short/Long Channel Switch Matrix

This block is the routing switch matrix of a simple configurable fabric. It sits between logic blocks and has four single-bit short channels and four single-bit long channels on each of its north, east, south and west sides. A short channel runs to the adjacent matrix. A long channel runs to the matrix two rows or two columns away. Short channel i is tied to long channel i. A net keeps its channel index through the whole fabric, so an output with index i can only take its value from inputs with index i. This removes any crossbar that would move a net from one channel index to another.

Each outgoing short and long channel wire has a 4-bit field. The field chooses what drives the wire: nothing (a constant 0), the short input of a chosen side at the same index, the long input of a chosen side at the same index, or the adjacent logic block's output bit for that index. The logic block also has one input tap per channel index. The tap can be disabled, or it can take the short input of a chosen side at that index.

Configuration is loaded one bit per clock into a shift chain while the enable is high. The matrix keeps routing with its previous configuration until a load-done strobe copies the chain into the active register. All routing from inputs to outputs is combinational. Only the configuration path is clocked.

Top module: `sm_pair_matrix`

## Requirements
- R1: While reset is asserted, and after it is released with no configuration loaded, every `short_out`, `long_out` and `lb_out` bit is 0.
- R2: The active configuration changes only on a clock edge where `cfg_done` is high. At that edge it takes the contents of the shift chain. Bits shifted in without a following `cfg_done` do not change the outputs.
- R3: A field whose mode bits [1:0] are 00 (off) drives its output to 0 whatever the inputs are.
- R4: Mode 01 drives output (side s, index i) from `short_in[src*NCH+i]`. Here src is field bits [3:2], with side codes north=0, east=1, south=2, west=3.
- R5: Mode 10 drives the output from `long_in[src*NCH+i]`.
- R6: Mode 11 drives the output from `lb_in[i]`.
- R7: An output with channel index i does not respond to any input with a different channel index.
- R8: Tap i drives `lb_out[i]` from `short_in[side*NCH+i]` when its enable bit (bit 2 of the tap field) is 1, and drives 0 when that bit is 0. The side is bits [1:0] of the tap field.
- R9: The shift chain moves only on edges where `cfg_en` is high. On each such edge `cfg_bit` enters at bit 0 and every other bit moves up by one. After CFG_W shifts, the first bit sent sits at the MSB. The chain layout is as follows. Output field f = ((side*NCH+i)*2+k), with k=0 for short and k=1 for long, occupies bits [4f+3:4f]. Tap field i occupies bits [NOUT*4+3i+2 : NOUT*4+3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, clears the chain and the active configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | input | 1 | Strobe that copies the chain into the active configuration |
| short_in | input | 4*NCH | Short channel inputs, bit side*NCH+index |
| long_in | input | 4*NCH | Long channel inputs, bit side*NCH+index |
| lb_in | input | NCH | Adjacent logic block outputs, one per channel index |
| short_out | output | 4*NCH | Short channel outputs, bit side*NCH+index |
| long_out | output | 4*NCH | Long channel outputs, bit side*NCH+index |
| lb_out | output | NCH | Taps to the adjacent logic block, one per channel index |

## Verification
The active configuration feeds the outputs combinationally, so a wrong active bit shows at the ports in the same cycle the vector is applied. A wrong bit can make an output take the wrong side, the wrong kind of channel, a 0 where a value is expected, or a value where 0 is expected. A fault in the shift chain only becomes visible after the next `cfg_done`: the outputs stay correct until the strobe and go wrong on the cycle after it. For that reason, outputs are checked both before and after each strobe, and the check vectors are chosen so that every side, mode and index gives a distinct value.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int NSIDE   = 4;
  localparam int SIDE_W  = 2;
  localparam int FIELD_W = 4;
  localparam int TAP_W   = 3;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'b00,
    DRV_SHORT = 2'b01,
    DRV_LONG  = 2'b10,
    DRV_LB    = 2'b11
  } drv_mode_e;

  typedef struct packed {
    logic [SIDE_W-1:0] src;
    drv_mode_e         mode;
  } out_field_t;

  typedef struct packed {
    logic              en;
    logic [SIDE_W-1:0] side;
  } tap_field_t;
endpackage

// File: rtl/sm_cfg_chain.sv
module sm_cfg_chain #(
  parameter int W = 140
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  input  logic         cfg_done,
  output logic [W-1:0] active
);
  logic [W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else if (cfg_en) begin
      chain <= {chain[W-2:0], cfg_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (cfg_done) begin
      active <= chain;
    end
  end

  // R2: the active copy holds between strobes
  p_hold_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> $stable(active));

  // R2: a strobe transfers the chain contents
  p_load_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> active == $past(chain));

  // R9: the chain is frozen while shifting is disabled
  p_chain_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(chain));

  // R9: new bit enters at the bottom
  p_chain_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> chain[0] == $past(cfg_bit));
endmodule

// File: rtl/sm_out_mux.sv
module sm_out_mux
  import sm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  out_field_t       fld,
  input  logic [NSIDE-1:0] short_col,
  input  logic [NSIDE-1:0] long_col,
  input  logic             lb_bit,
  output logic             drv
);
  always_comb begin
    unique case (fld.mode)
      DRV_SHORT: drv = short_col[fld.src];
      DRV_LONG:  drv = long_col[fld.src];
      DRV_LB:    drv = lb_bit;
      default:   drv = 1'b0;
    endcase
  end

  // R3: an unconfigured wire never carries a value
  p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fld.mode == DRV_OFF) |-> !drv);

  // R6: logic-block drive follows the block output
  p_lb_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fld.mode == DRV_LB) |-> drv == lb_bit);
endmodule

// File: rtl/sm_tap_mux.sv
module sm_tap_mux
  import sm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tap_field_t       fld,
  input  logic [NSIDE-1:0] short_col,
  output logic             tap
);
  always_comb begin
    tap = 1'b0;
    if (fld.en) tap = short_col[fld.side];
  end

  // R8: a disabled tap stays low
  p_tap_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fld.en |-> !tap);
endmodule

// File: rtl/sm_pair_matrix.sv
module sm_pair_matrix
  import sm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_bit,
  input  logic                 cfg_done,
  input  logic [NSIDE*NCH-1:0] short_in,
  input  logic [NSIDE*NCH-1:0] long_in,
  input  logic [NCH-1:0]       lb_in,
  output logic [NSIDE*NCH-1:0] short_out,
  output logic [NSIDE*NCH-1:0] long_out,
  output logic [NCH-1:0]       lb_out
);
  localparam int NOUT   = NSIDE * NCH * 2;
  localparam int TAP_LO = NOUT * FIELD_W;
  localparam int CFG_W  = TAP_LO + NCH * TAP_W;

  logic [CFG_W-1:0] active;
  logic [NSIDE-1:0] short_col [NCH];
  logic [NSIDE-1:0] long_col  [NCH];

  sm_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_bit  (cfg_bit),
    .cfg_done (cfg_done),
    .active   (active)
  );

  // regroup inputs by channel index; a net never leaves its index
  for (genvar i = 0; i < NCH; i++) begin : g_col
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      assign short_col[i][s] = short_in[s*NCH+i];
      assign long_col[i][s]  = long_in[s*NCH+i];
    end
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_out_side
    for (genvar i = 0; i < NCH; i++) begin : g_out_idx
      localparam int FS = (s*NCH + i) * 2;
      localparam int FL = FS + 1;

      sm_out_mux u_short (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld       (out_field_t'(active[FS*FIELD_W +: FIELD_W])),
        .short_col (short_col[i]),
        .long_col  (long_col[i]),
        .lb_bit    (lb_in[i]),
        .drv       (short_out[s*NCH+i])
      );

      sm_out_mux u_long (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld       (out_field_t'(active[FL*FIELD_W +: FIELD_W])),
        .short_col (short_col[i]),
        .long_col  (long_col[i]),
        .lb_bit    (lb_in[i]),
        .drv       (long_out[s*NCH+i])
      );
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_tap
    sm_tap_mux u_tap (
      .clk       (clk),
      .rst_n     (rst_n),
      .fld       (tap_field_t'(active[TAP_LO + i*TAP_W +: TAP_W])),
      .short_col (short_col[i]),
      .tap       (lb_out[i])
    );
  end

  // R1: outputs are quiet right after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (short_out == '0 || active != '0));
endmodule

// File: tb/sm_pair_matrix_bench.sv
module sm_pair_matrix_bench;
  localparam int NCH   = 4;
  localparam int NS    = 4;
  localparam int NB    = NS * NCH;
  localparam int NOUT  = NB * 2;
  localparam int TLO   = NOUT * 4;
  localparam int CW    = TLO + NCH * 3;
  localparam int OW    = 2 * NB + NCH;
  localparam int IW    = 2 * NB + NCH;
  localparam int NVEC  = 8;

  // stimulus: {short_in, long_in, lb_in}
  localparam logic [IW-1:0] VEC [NVEC] = '{
    36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'h1_2345_6789,
    36'hA_5A5A_A5A5, 36'h5_F00F_0FF0, 36'h0_FFFF_0000,
    36'h3_0000_FFFF, 36'hC_8421_1248
  };

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_bit = 0, cfg_done = 0;
  logic [NB-1:0]  short_in = '0, long_in = '0;
  logic [NCH-1:0] lb_in = '0;
  logic [NB-1:0]  short_out, long_out;
  logic [NCH-1:0] lb_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sm_pair_matrix #(.NCH(NCH)) u_sm_pair_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .short_in(short_in), .long_in(long_in),
    .lb_in(lb_in), .short_out(short_out), .long_out(long_out),
    .lb_out(lb_out)
  );

  function automatic logic [CW-1:0] cfg_a();
    logic [CW-1:0] c = '0;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NCH; i++)
        for (int k = 0; k < 2; k++) begin
          int f = (s*NCH + i)*2 + k;
          c[f*4 +: 2]   = 2'((s + i + k) % 4);
          c[f*4+2 +: 2] = 2'((s + 1 + i) % 4);
        end
    for (int i = 0; i < NCH; i++) c[TLO + i*3 +: 3] = {(i != 3), 2'(i)};
    return c;
  endfunction

  // every output takes the short input of side 0; every tap reads side 2
  function automatic logic [CW-1:0] cfg_b();
    logic [CW-1:0] c = '0;
    for (int f = 0; f < NOUT; f++) c[f*4 +: 4] = 4'b0001;
    for (int i = 0; i < NCH; i++) c[TLO + i*3 +: 3] = 3'b110;
    return c;
  endfunction

  function automatic logic [OW-1:0] model(logic [CW-1:0] c, logic [IW-1:0] v);
    logic [NB-1:0] si = v[IW-1 -: NB];
    logic [NB-1:0] li = v[NCH +: NB];
    logic [NCH-1:0] lb = v[NCH-1:0];
    logic [NB-1:0] so = '0, lo = '0;
    logic [NCH-1:0] t = '0;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NCH; i++)
        for (int k = 0; k < 2; k++) begin
          int f = (s*NCH + i)*2 + k;
          logic [1:0] m = c[f*4 +: 2];
          int src = int'(c[f*4+2 +: 2]);
          logic b = (m == 2'd1) ? si[src*NCH+i] :
                    (m == 2'd2) ? li[src*NCH+i] :
                    (m == 2'd3) ? lb[i] : 1'b0;
          if (k == 0) so[s*NCH+i] = b; else lo[s*NCH+i] = b;
        end
    for (int i = 0; i < NCH; i++)
      t[i] = c[TLO+i*3+2] ? si[int'(c[TLO+i*3 +: 2])*NCH+i] : 1'b0;
    return {t, lo, so};
  endfunction

  task automatic apply(logic [IW-1:0] v);
    @(negedge clk);
    short_in = v[IW-1 -: NB];
    long_in  = v[NCH +: NB];
    lb_in    = v[NCH-1:0];
    #1;
  endtask

  task automatic check_all(logic [CW-1:0] c, logic [IW-1:0] v, string ctx);
    logic [OW-1:0] exp = model(c, v);
    logic [OW-1:0] act = {lb_out, long_out, short_out};
    for (int b = 0; b < OW; b++) begin
      string tag;
      if (b >= 2*NB) tag = "R8";
      else begin
        int f = (b < NB) ? b*2 : (b-NB)*2 + 1;
        case (c[f*4 +: 2])
          2'd0: tag = "R3"; 2'd1: tag = "R4";
          2'd2: tag = "R5"; default: tag = "R6";
        endcase
      end
      checks++;
      if (act[b] !== exp[b]) begin
        errors++;
        $display("FAIL %s %s bit %0d actual %b expected %b", tag, ctx, b, act[b], exp[b]);
      end
    end
  endtask

  task automatic shift_cfg(logic [CW-1:0] c);
    for (int b = CW-1; b >= 0; b--) begin
      @(negedge clk); cfg_en = 1; cfg_bit = c[b];
    end
    @(negedge clk); cfg_en = 0; cfg_bit = 0;
  endtask

  task automatic strobe();
    @(negedge clk); cfg_done = 1;
    @(negedge clk); cfg_done = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] ca = cfg_a();
    logic [CW-1:0] cb = cfg_b();
    // R1: reset, all outputs low
    apply(VEC[1]);
    check_all('0, VEC[1], "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    apply(VEC[2]);
    check_all('0, VEC[2], "R1 after reset");

    // R2: loading without a strobe leaves outputs unchanged
    shift_cfg(ca);
    apply(VEC[1]);
    check_all('0, VEC[1], "R2 before strobe");
    strobe();

    // table walk under configuration A
    for (int n = 0; n < NVEC; n++) begin
      apply(VEC[n]);
      check_all(ca, VEC[n], "cfgA vector");
    end

    // R2: a new chain shifted in, no strobe: still configuration A
    shift_cfg(cb);
    apply(VEC[3]);
    check_all(ca, VEC[3], "R2 chain not applied");

    // R9: bits offered with enable low must not enter the chain
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); cfg_bit = 1'(k);
    end
    strobe();
    apply(VEC[4]);
    check_all(cb, VEC[4], "R9 chain unchanged");

    // R7: only index 2 inputs active, so only index 2 outputs may rise
    apply({16'h4444, 16'h4444, 4'h4});
    check_all(cb, {16'h4444, 16'h4444, 4'h4}, "R7 index 2");
    checks++;
    if ((short_out & 16'hBBBB) !== '0 || (lb_out & 4'hB) !== '0) begin
      errors++;
      $display("FAIL R7 actual %h/%h expected zero off index 2", short_out, lb_out);
    end

    // R1: reset again clears the active configuration
    @(negedge clk); rst_n = 0;
    apply(VEC[1]);
    check_all('0, VEC[1], "R1 re-reset");
    @(negedge clk); rst_n = 1;
    apply(VEC[1]);
    check_all('0, VEC[1], "R1 after re-reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule